// File: doc/BRIEF.md
# Ethernet Management Bus Master

This block drives the two-wire Ethernet management bus toward one or more PHYs. It divides the system clock down to the management clock (MDC) and shifts Clause 22 or Clause 45 frames onto the shared MDIO line. It releases the line while a PHY answers a read. Software-facing state is kept in four small holding registers: a control word (port address, device or register address, read request), an address word, a data word and a set of configuration inputs. A frame starts when one of these registers is written, and a busy flag tracks it until the final bit has been clocked.

A Clause 22 access takes one frame. A Clause 45 access takes two frames: first an address frame, then a write or read frame, and each is started by its own register write. The configuration selects the MDC divisor, the hold time applied after the driving MDC edge, which MDC edge drives the line, preamble suppression and the clause. The configuration is latched when a frame starts, so changes made while a frame runs take effect on the next frame. Two sticky flags are set by faults and cleared together by a clear strobe. One flag marks a launching write that arrived while busy. The other marks a read in which the PHY did not pull the second turnaround bit low.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The MDC period is 2·DIV system clocks, with DIV taken from `cfg_div` and a value of 0 treated as 1. MDC is low whenever `busy` is low.
- R2: After its driving MDC edge, MDIO changes H system clocks later. With `cfg_ext_hold`=0, H = 2·N, where N is `cfg_hold`. With `cfg_ext_hold`=1, H = 8·(N−1)+2, and N=0 behaves as N=1. Software keeps H below DIV.
- R3: With `cfg_fall`=0 the driving edge is the rising edge of MDC. With `cfg_fall`=1 it is the falling edge. The PHY samples on every rising edge.
- R4: With `cfg_no_pre`=0 each frame opens with 32 ones. With `cfg_no_pre`=1 the frame starts directly at the start bits, so it is 64 or 32 MDC cycles long.
- R5: With `cfg_c45`=0, writing the data word launches a write frame and writing the control word with `ctl_rd`=1 launches a read frame. The frame is sent MSB first as start `01`, opcode (`01` write, `10` read), 5-bit port, 5-bit register address, turnaround (`10` on writes) and 16 data bits.
- R6: With `cfg_c45`=1 the start is `00`. Writing the address word launches an address frame (opcode `00`, payload = address word). A data-word write launches opcode `01`, and a control write with `ctl_rd`=1 launches opcode `11`. With `cfg_c45`=0, an address-word write only stores the value.
- R7: In a read frame, `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround are readable on `rd_data` once `busy` is low.
- R8: `busy` rises on the clock edge that accepts a launching write. It falls with the MDC falling edge that follows the last sampled bit. `mdio_oe` is low while `busy` is low.
- R9: `rd_err` is set, and stays set, when a read samples the second turnaround bit high.
- R10: A launching write that arrives while `busy` is high is dropped: no register changes and no frame starts. It sets the sticky `addr_err`.
- R11: `err_clr` clears `addr_err` and `rd_err`. A control write with `ctl_rd`=0 launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | MDC half-period in system clocks |
| cfg_hold | input | HOLD_W | Hold field N |
| cfg_ext_hold | input | 1 | Selects the extended hold encoding |
| cfg_no_pre | input | 1 | Suppresses the preamble |
| cfg_fall | input | 1 | Drive MDIO after the falling MDC edge |
| cfg_c45 | input | 1 | Clause 45 encoding |
| ctl_we | input | 1 | Control word write strobe |
| ctl_port | input | 5 | Port (PHY) address |
| ctl_dev | input | 5 | Device or register address |
| ctl_rd | input | 1 | Read request |
| addr_we | input | 1 | Address word write strobe |
| addr_wdata | input | 16 | Address word value |
| data_we | input | 1 | Data word write strobe |
| data_wdata | input | 16 | Data word value |
| err_clr | input | 1 | Clears both sticky flags |
| rd_data | output | 16 | Data word content |
| busy | output | 1 | Frame in progress |
| addr_err | output | 1 | Sticky collision flag |
| rd_err | output | 1 | Sticky turnaround flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The hardest cases to reach from the ports are the timing corners. One is an H=0 change that coincides with a sampling edge. Another is an extended hold that only fits under a large divisor. A third is a write that lands while a frame runs. A PHY model in the bench logs every bit on each rising MDC edge, using the value held just before the edge, and measures the clocks from each driving edge to each MDIO change. Seeded random frames cover the clause, kind, edge, preamble and divisor settings. Directed frames add an extended hold of 10 clocks, a divisor of 0, a PHY that leaves the turnaround high, and a data write injected mid-frame.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

    localparam int FRAME_BITS = 64;
    localparam int ADR_W      = 5;
    localparam int WORD_W     = 16;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    // bit positions inside the 64-bit frame (preamble occupies 0..31)
    localparam logic [IDX_W-1:0] BODY_IDX = IDX_W'(32);
    localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(46);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(47);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(48);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(63);

    typedef enum logic [1:0] {
        FR_ADDR  = 2'd0,
        FR_WRITE = 2'd1,
        FR_READ  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        logic no_pre;
        logic fall;
        logic c45;
    } mode_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_ev,
    output logic             fall_ev
);
    localparam int CW = DIV_W + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t g_d, g_q;
    logic [CW-1:0] half, full;

    always_comb begin
        half    = (div == '0) ? CW'(1) : CW'(div);
        full    = half << 1;
        g_d     = g_q;
        rise_ev = 1'b0;
        fall_ev = 1'b0;
        if (!run) begin
            g_d.cnt = '0;
            g_d.mdc = 1'b0;
        end else if (g_q.cnt == full - CW'(1)) begin
            g_d.cnt = '0;
            g_d.mdc = 1'b0;
            fall_ev = 1'b1;
        end else begin
            g_d.cnt = g_q.cnt + CW'(1);
            if (g_q.cnt + CW'(1) == half) begin
                g_d.mdc = 1'b1;
                rise_ev = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign mdc = g_q.mdc;

    // R1
    mdc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_hold_timer.sv
module mdio_hold_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              edge_ev,
    input  logic [HOLD_W-1:0] n,
    input  logic              ext,
    output logic              step
);
    localparam int TW = HOLD_W + 4;

    typedef struct packed {
        logic          act;
        logic [TW-1:0] cnt;
    } hold_t;

    hold_t h_d, h_q;
    logic [TW-1:0] hclk;

    always_comb begin
        if (ext) hclk = (n == '0) ? TW'(2) : ((TW'(n) - TW'(1)) << 3) + TW'(2);
        else     hclk = TW'(n) << 1;
    end

    always_comb begin
        h_d  = h_q;
        step = 1'b0;
        if (clr) begin
            h_d = '0;
        end else if (edge_ev) begin
            h_d.cnt = '0;
            if (hclk == '0) begin
                step    = 1'b1;
                h_d.act = 1'b0;
            end else begin
                h_d.act = 1'b1;
            end
        end else if (h_q.act) begin
            if (h_q.cnt + TW'(1) == hclk) begin
                step    = 1'b1;
                h_d.act = 1'b0;
            end else begin
                h_d.cnt = h_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    // R2
    hold_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.act |-> h_q.cnt < hclk);

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_master_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic [IDX_W-1:0]      start_idx,
    input  logic                  is_read,
    input  logic                  rise_ev,
    input  logic                  fall_ev,
    input  logic                  step,
    input  logic                  mdio_i,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [WORD_W-1:0]     cap,
    output logic                  ta_bad
);
    typedef struct packed {
        logic [FRAME_BITS-1:0] frame;
        logic [IDX_W-1:0]      oidx;
        logic [IDX_W-1:0]      sidx;
        logic                  last;
        logic                  rd;
        logic                  o;
        logic                  oe;
        logic [WORD_W-1:0]     cap;
        logic                  tabad;
    } shf_t;

    shf_t s_d, s_q;
    logic [IDX_W-1:0] nxt;

    function automatic logic pick(input logic [FRAME_BITS-1:0] f, input logic [IDX_W-1:0] i);
        return f[LAST_IDX - i];
    endfunction

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        nxt  = s_q.oidx + IDX_W'(1);
        if (load) begin
            s_d.frame = frame;
            s_d.oidx  = start_idx;
            s_d.sidx  = start_idx;
            s_d.last  = 1'b0;
            s_d.rd    = is_read;
            s_d.o     = pick(frame, start_idx);
            s_d.oe    = 1'b1;
            s_d.cap   = '0;
            s_d.tabad = 1'b0;
        end else begin
            if (rise_ev && !s_q.last) begin
                if (s_q.rd && s_q.sidx == TA2_IDX && mdio_i) s_d.tabad = 1'b1;
                if (s_q.rd && s_q.sidx >= DAT_IDX) s_d.cap = {s_q.cap[WORD_W-2:0], mdio_i};
                if (s_q.sidx == LAST_IDX) s_d.last = 1'b1;
                else                      s_d.sidx = s_q.sidx + IDX_W'(1);
            end
            if (step && !s_q.last && s_q.oidx != LAST_IDX) begin
                s_d.oidx = nxt;
                s_d.o    = pick(s_q.frame, nxt);
                s_d.oe   = !(s_q.rd && nxt >= REL_IDX);
            end
            if (fall_ev && s_q.last) begin
                done     = 1'b1;
                s_d.last = 1'b0;
                s_d.oe   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.frame <= '1;
            s_q.o     <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdio_o  = s_q.o;
    assign mdio_oe = s_q.oe;
    assign cap     = s_q.cap;
    assign ta_bad  = s_q.tabad;

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rd && s_q.sidx >= TA2_IDX) |-> !s_q.oe);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_master_pkg::*;
#(
    parameter int DIV_W  = 9,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              cfg_ext_hold,
    input  logic              cfg_no_pre,
    input  logic              cfg_fall,
    input  logic              cfg_c45,
    input  logic              ctl_we,
    input  logic [4:0]        ctl_port,
    input  logic [4:0]        ctl_dev,
    input  logic              ctl_rd,
    input  logic              addr_we,
    input  logic [15:0]       addr_wdata,
    input  logic              data_we,
    input  logic [15:0]       data_wdata,
    input  logic              err_clr,
    output logic [15:0]       rd_data,
    output logic              busy,
    output logic              addr_err,
    output logic              rd_err,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    typedef struct packed {
        logic [ADR_W-1:0]  port;
        logic [ADR_W-1:0]  dev;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              busy;
        logic              aerr;
        logic              rerr;
        frame_kind_e       kind;
        logic [DIV_W-1:0]  div;
        logic [HOLD_W-1:0] hold;
        logic              ext;
        mode_t             mode;
    } top_t;

    top_t r_d, r_q;

    logic                  launch;
    frame_kind_e           lkind;
    logic [FRAME_BITS-1:0] frame;
    logic [1:0]            st_bits, op_bits, ta_bits;
    logic [WORD_W-1:0]     payload;
    logic                  rise_ev, fall_ev, step, done, ta_bad;
    logic [WORD_W-1:0]     cap;

    always_comb begin
        r_d    = r_q;
        launch = 1'b0;
        lkind  = FR_WRITE;
        if (err_clr) begin
            r_d.aerr = 1'b0;
            r_d.rerr = 1'b0;
        end
        if (ctl_we) begin
            if (ctl_rd && r_q.busy) begin
                r_d.aerr = 1'b1;
            end else begin
                r_d.port = ctl_port;
                r_d.dev  = ctl_dev;
                if (ctl_rd) begin
                    launch = 1'b1;
                    lkind  = FR_READ;
                end
            end
        end else if (addr_we) begin
            if (cfg_c45 && r_q.busy) begin
                r_d.aerr = 1'b1;
            end else begin
                r_d.addr = addr_wdata;
                if (cfg_c45) begin
                    launch = 1'b1;
                    lkind  = FR_ADDR;
                end
            end
        end else if (data_we) begin
            if (r_q.busy) begin
                r_d.aerr = 1'b1;
            end else begin
                r_d.data = data_wdata;
                launch   = 1'b1;
                lkind    = FR_WRITE;
            end
        end
        if (launch) begin
            r_d.busy        = 1'b1;
            r_d.kind        = lkind;
            r_d.div         = cfg_div;
            r_d.hold        = cfg_hold;
            r_d.ext         = cfg_ext_hold;
            r_d.mode.no_pre = cfg_no_pre;
            r_d.mode.fall   = cfg_fall;
            r_d.mode.c45    = cfg_c45;
        end
        if (done) begin
            r_d.busy = 1'b0;
            if (r_q.kind == FR_READ) begin
                r_d.data = cap;
                if (ta_bad) r_d.rerr = 1'b1;
            end
        end
    end

    // frame image built from the values being accepted this cycle
    always_comb begin
        st_bits = cfg_c45 ? 2'b00 : 2'b01;
        ta_bits = 2'b10;
        payload = r_d.data;
        unique case (lkind)
            FR_ADDR: begin
                op_bits = 2'b00;
                payload = r_d.addr;
            end
            FR_READ: begin
                op_bits = cfg_c45 ? 2'b11 : 2'b10;
                ta_bits = 2'b11;
                payload = '1;
            end
            default: op_bits = cfg_c45 ? 2'b01 : 2'b01;
        endcase
        frame = {32'hFFFF_FFFF, st_bits, op_bits, r_d.port, r_d.dev, ta_bits, payload};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.kind <= FR_WRITE;
        end else begin
            r_q <= r_d;
        end
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.busy),
        .div     (r_q.div),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_hold_timer #(.HOLD_W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (!r_q.busy),
        .edge_ev (r_q.mode.fall ? fall_ev : rise_ev),
        .n       (r_q.hold),
        .ext     (r_q.ext),
        .step    (step)
    );

    mdio_frame_shifter u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .frame     (frame),
        .start_idx (cfg_no_pre ? BODY_IDX : '0),
        .is_read   (lkind == FR_READ),
        .rise_ev   (rise_ev),
        .fall_ev   (fall_ev),
        .step      (step),
        .mdio_i    (mdio_i),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .done      (done),
        .cap       (cap),
        .ta_bad    (ta_bad)
    );

    assign rd_data  = r_q.data;
    assign busy     = r_q.busy;
    assign addr_err = r_q.aerr;
    assign rd_err   = r_q.rerr;

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R8
    launch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !mdc);

    // R10
    collide_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_err) |-> $past(busy));

    // R9
    rderr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err) |-> $past(r_q.kind) == FR_READ);

endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  cfg_div = 9'd4;
    logic [3:0]  cfg_hold = 4'd0;
    logic        cfg_ext_hold = 1'b0, cfg_no_pre = 1'b0, cfg_fall = 1'b0, cfg_c45 = 1'b0;
    logic        ctl_we = 1'b0, ctl_rd = 1'b0, addr_we = 1'b0, data_we = 1'b0, err_clr = 1'b0;
    logic [4:0]  ctl_port = '0, ctl_dev = '0;
    logic [15:0] addr_wdata = '0, data_wdata = '0;
    logic [15:0] rd_data;
    logic        busy, addr_err, rd_err, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #4 clk = ~clk;

    mdio_mgmt_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_hold(cfg_hold),
        .cfg_ext_hold(cfg_ext_hold), .cfg_no_pre(cfg_no_pre), .cfg_fall(cfg_fall),
        .cfg_c45(cfg_c45), .ctl_we(ctl_we), .ctl_port(ctl_port), .ctl_dev(ctl_dev),
        .ctl_rd(ctl_rd), .addr_we(addr_we), .addr_wdata(addr_wdata), .data_we(data_we),
        .data_wdata(data_wdata), .err_clr(err_clr), .rd_data(rd_data), .busy(busy),
        .addr_err(addr_err), .rd_err(rd_err), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    // PHY model / monitor state
    int  cyc = 0, nb = 0, last_rise = 0, edge_cyc = 0, per_bad = 0, hold_bad = 0, hold_seen = 0;
    bit  have_rise = 0, have_edge = 0;
    logic mdc_p = 0, o_p = 1, oe_p = 0, busy_p = 0;
    logic [63:0] lo, loe;
    int  exp_div = 4, exp_h = 0, exp_pre = 32;
    bit  exp_fall = 0, phy_read = 0, phy_ta_ok = 1;
    logic [15:0] phy_resp = '0;

    always @(negedge clk) begin
        int bi;
        cyc++;
        if (busy && !busy_p) begin
            nb = 0; have_rise = 0; have_edge = 0; per_bad = 0; hold_bad = 0; hold_seen = 0;
        end
        if (mdc && !mdc_p) begin
            if (nb < 64) begin lo[nb] = o_p; loe[nb] = oe_p; end
            nb++;
            if (have_rise && (cyc - last_rise) != 2 * exp_div) per_bad++;
            have_rise = 1; last_rise = cyc;
            if (!exp_fall) begin have_edge = 1; edge_cyc = cyc; end
        end
        if (!mdc && mdc_p) begin
            if (exp_fall) begin have_edge = 1; edge_cyc = cyc; end
            bi = nb - exp_pre;
            if (phy_read && bi == 15)                   mdio_i = !phy_ta_ok;
            else if (phy_read && bi >= 16 && bi <= 31)  mdio_i = phy_resp[31 - bi];
            else                                        mdio_i = 1'b1;
        end
        if (busy && busy_p && mdio_oe && oe_p && mdio_o != o_p) begin
            hold_seen++;
            if (!have_edge || (cyc - edge_cyc) != exp_h) hold_bad++;
        end
        if (!busy) mdio_i = 1'b1;
        mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe; busy_p = busy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int hold_of(input int n, input bit ext);
        if (ext) return (n == 0) ? 2 : 8 * (n - 1) + 2;
        return 2 * n;
    endfunction

    // kind: 0 address, 1 write, 2 read
    function automatic logic [31:0] body_of(input bit c45, input int kind, input logic [4:0] pa,
                                            input logic [4:0] da, input logic [15:0] ad,
                                            input logic [15:0] dt);
        logic [1:0] st, op;
        st = c45 ? 2'b00 : 2'b01;
        if (kind == 0)      op = 2'b00;
        else if (kind == 1) op = 2'b01;
        else                op = c45 ? 2'b11 : 2'b10;
        return {st, op, pa, da, 2'b10, (kind == 0) ? ad : dt};
    endfunction

    task automatic pulse_we(input int which);
        @(negedge clk);
        if (which == 0) ctl_we = 1; else if (which == 1) addr_we = 1; else data_we = 1;
        @(negedge clk);
        ctl_we = 0; addr_we = 0; data_we = 0; ctl_rd = 0;
    endtask

    task automatic wr_ctl(input logic [4:0] pa, input logic [4:0] da, input bit rd);
        ctl_port = pa; ctl_dev = da; ctl_rd = rd;
        pulse_we(0);
    endtask

    task automatic run_frame(input int kind, input bit c45, input logic [4:0] pa, input logic [4:0] da,
                             input logic [15:0] ad, input logic [15:0] dt, input int div,
                             input int n, input bit ext, input bit fall, input bit nopre,
                             input logic [15:0] resp, input bit ta_ok, input bit collide);
        logic [31:0] body;
        int len, pre;
        bit bits_ok, rel_ok;
        string rq;
        cfg_div = 9'(div); cfg_hold = 4'(n); cfg_ext_hold = ext; cfg_fall = fall;
        cfg_no_pre = nopre; cfg_c45 = c45;
        exp_div = (div == 0) ? 1 : div; exp_h = hold_of(n, ext); exp_fall = fall;
        exp_pre = nopre ? 0 : 32; phy_read = (kind == 2); phy_resp = resp; phy_ta_ok = ta_ok;
        rq = c45 ? "R6" : "R5";
        wr_ctl(pa, da, 0);
        repeat (2) @(negedge clk);
        // R11: control write without read request starts nothing
        chk(busy == 0, "R11", "busy after ctl write without read", 64'(busy), 0);
        if (kind == 2) wr_ctl(pa, da, 1);
        else if (kind == 0) begin addr_wdata = ad; pulse_we(1); end
        else begin data_wdata = dt; pulse_we(2); end
        // R8: busy is up right after the accepting edge
        chk(busy == 1, "R8", "busy after launch", 64'(busy), 1);
        if (collide) begin
            repeat (10) @(negedge clk);
            data_wdata = 16'hDEAD; pulse_we(2);
            chk(addr_err == 1, "R10", "addr_err after write while busy", 64'(addr_err), 1);
        end
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        body = body_of(c45, kind, pa, da, ad, dt);
        pre = nopre ? 0 : 32;
        len = pre + 32;
        chk(nb == len, "R4", "frame length", 64'(nb), 64'(len));
        bits_ok = 1; rel_ok = 1;
        for (int i = 0; i < len && i < 64; i++) begin
            logic eb;
            bit drv;
            eb  = (i < pre) ? 1'b1 : body[31 - (i - pre)];
            drv = !(kind == 2 && (i - pre) >= 14);
            if (drv && !(loe[i] === 1'b1 && lo[i] === eb)) bits_ok = 0;
            if (!drv && loe[i] !== 1'b0) rel_ok = 0;
        end
        chk(bits_ok, rq, "frame bits", lo, {32'hFFFF_FFFF, body});
        if (kind == 2) chk(rel_ok, "R7", "line released in read", loe, 0);
        // R1
        chk(per_bad == 0, "R1", "MDC period errors", 64'(per_bad), 0);
        // R2 and R3: each change follows the selected edge by H clocks
        chk(hold_bad == 0 && hold_seen > 0, fall ? "R3" : "R2", "hold timing errors",
            64'(hold_bad), 0);
        if (kind == 2) begin
            chk(rd_data == resp, "R7", "read data", 64'(rd_data), 64'(resp));
            chk(rd_err == !ta_ok, "R9", "rd_err", 64'(rd_err), 64'(!ta_ok));
        end else if (kind == 1) begin
            chk(rd_data == dt, "R10", "data word after write", 64'(rd_data), 64'(dt));
        end
        if (addr_err || rd_err) begin
            @(negedge clk) err_clr = 1;
            @(negedge clk) err_clr = 0;
            chk(addr_err == 0 && rd_err == 0, "R11", "flags after clear",
                64'({addr_err, rd_err}), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R8)
        chk(busy == 0 && mdc == 0 && mdio_oe == 0, "R8", "reset outputs",
            64'({busy, mdc, mdio_oe}), 0);
        chk(addr_err == 0 && rd_err == 0 && rd_data == 0, "R9", "reset flags",
            64'({addr_err, rd_err, rd_data}), 0);

        // directed corners
        run_frame(1, 0, 5'h01, 5'h02, 16'h0, 16'hA5C3, 4, 1, 0, 0, 0, 16'h0, 1, 0);
        run_frame(2, 0, 5'h1F, 5'h10, 16'h0, 16'h0, 3, 0, 0, 1, 0, 16'h8E71, 1, 0);
        run_frame(2, 1, 5'h03, 5'h07, 16'h0, 16'h0, 4, 1, 0, 0, 1, 16'h1234, 0, 0); // R9 bad TA
        run_frame(0, 1, 5'h0A, 5'h01, 16'hBEEF, 16'h0, 12, 2, 1, 0, 0, 16'h0, 1, 0); // R2 ext hold 10
        run_frame(1, 1, 5'h0A, 5'h01, 16'h0, 16'h5A5A, 12, 1, 1, 1, 1, 16'h0, 1, 0);
        run_frame(1, 0, 5'h11, 5'h05, 16'h0, 16'h0F0F, 0, 0, 0, 0, 0, 16'h0, 1, 0);  // R1 div 0
        run_frame(1, 0, 5'h02, 5'h04, 16'h0, 16'h3C3C, 5, 2, 0, 0, 0, 16'h0, 1, 1);  // R10 collision
        // R10: no second frame after the dropped write
        repeat (20) @(negedge clk);
        chk(busy == 0, "R10", "no frame from dropped write", 64'(busy), 0);

        // R6: address word write in Clause 22 mode only stores
        cfg_c45 = 0; addr_wdata = 16'h7777; pulse_we(1);
        repeat (3) @(negedge clk);
        chk(busy == 0 && mdc == 0, "R6", "no launch on C22 address write", 64'(busy), 0);

        // seeded random frames
        for (int k = 0; k < 24; k++) begin
            int div, n, kind;
            bit c45, ext;
            div  = 2 + int'($urandom % 7);
            c45  = $urandom % 2;
            kind = c45 ? int'($urandom % 3) : 1 + int'($urandom % 2);
            ext  = (div > 2) && ($urandom % 4 == 0);
            n    = ext ? 1 : int'($urandom % ((div - 1) / 2 + 1));
            run_frame(kind, c45, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom),
                      div, n, ext, $urandom % 2, $urandom % 2, 16'($urandom),
                      ($urandom % 5) != 0, 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule